// File: doc/BRIEF.md
# Packed Lane Integer Adder with Saturating and Halving Modifiers

This block adds or subtracts two 128-bit operand vectors as packed integers. A size select cuts each vector into sixteen 8-bit, eight 16-bit, four 32-bit or two 64-bit lanes. Every lane runs the same operation in the same cycle. Control inputs select signed or unsigned operands and addition or subtraction. A modifier then picks one of four outputs: the plain wrapped result, a result clamped to the lane type's range, the halved full-precision result, or the halved result with rounding.

A single adder built from 8-bit segments serves every lane size. The size select cuts the carry chain between segments at lane edges. Each lane also forms one extra result bit above its width, so the halving and clamping logic works on the exact sum or difference. The result and a per-lane clamp flag are registered and appear one clock after a valid input. A sticky status bit records that at least one clamp has occurred since it was last cleared. There is no backpressure.

Top module: `packed_lane_adder`

## Requirements
- R1: `lane_size` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies result bits [i*W +: W] and is computed only from the operand bits at the same position. No carry or borrow passes between lanes.
- R2: With `mode` 0 (wrap), each lane returns the low W bits of a+b, or of a-b when `is_sub` is 1.
- R3: With `mode` 1 (saturate) and `is_signed` 1, a lane result above 2^(W-1)-1 becomes 2^(W-1)-1, and one below -2^(W-1) becomes -2^(W-1). That lane's `lane_sat` bit is set. Otherwise the lane returns the exact result and its bit is clear.
- R4: With `mode` 1 and `is_signed` 0, an unsigned sum above 2^W-1 becomes 2^W-1 and a negative difference becomes 0, with the lane's `lane_sat` bit set. `lane_sat` bit i belongs to lane i. Bits at or above the lane count, and all bits in the other modes, are 0.
- R5: With `mode` 2 (halve), each lane returns floor(v/2), where v is the full-precision sum or difference of the operands sign-extended (`is_signed` 1) or zero-extended (`is_signed` 0). Only the low W bits are kept.
- R6: With `mode` 3 (rounding halve), each lane returns the low W bits of floor((v+1)/2).
- R7: `out_valid` equals `in_valid` delayed by one clock. `result` and `lane_sat` update one clock after a cycle with `in_valid` high and hold their values after a cycle with `in_valid` low.
- R8: `sat_status` goes to 1 one clock after a valid operation that sets any `lane_sat` bit, and stays 1 until `sat_clr` is high. `sat_clr` clears it one clock later, unless a clamping operation is accepted in that same cycle, in which case it stays 1.
- R9: While `rst_n` is low, `out_valid`, `result`, `lane_sat` and `sat_status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| lane_size | input | 2 | Lane width select: 0=8, 1=16, 2=32, 3=64 bits |
| is_signed | input | 1 | 1 treats lanes as two's complement, 0 as unsigned |
| is_sub | input | 1 | 1 computes a-b, 0 computes a+b |
| mode | input | 2 | 0 wrap, 1 saturate, 2 halve, 3 rounding halve |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector |
| sat_clr | input | 1 | Clears the sticky status bit |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 128 | Packed lane results |
| lane_sat | output | 16 | Per-lane clamp flags of the last result |
| sat_status | output | 1 | Sticky record of any clamp |

## Verification
The bench sweeps every lane size, modifier, signedness and direction. It biases each lane toward zero, all-ones, the sign bit alone and the largest positive value, because these are where carries leak, clamps pick the wrong bound and halving loses its top bit. If a lane edge is cut in the wrong place, carries from 0xFF-style lanes corrupt the neighbouring lane. If the extra bit is dropped, halving a large sum loses its most significant bit, and unsigned subtraction clamps to the maximum instead of zero. Rounding that is applied before the extension, or added after truncation, is off by one on odd sums. Further directed checks cover hold behaviour when `in_valid` is low, and a clear that arrives in the same cycle as a new clamp.

// File: rtl/plad_pkg.sv
package plad_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } lane_size_e;

    typedef enum logic [1:0] {
        MD_WRAP  = 2'd0,
        MD_SAT   = 2'd1,
        MD_HALF  = 2'd2,
        MD_RHALF = 2'd3
    } add_mode_e;

    localparam int NUM_SIZES = 4;

endpackage

// File: rtl/seg_adder.sv
module seg_adder #(
    parameter int NSEG  = 16,
    parameter int SEG_W = 8
) (
    input  logic [NSEG*SEG_W-1:0] a_i,
    input  logic [NSEG*SEG_W-1:0] b_i,
    input  logic                  sub_i,
    input  logic [NSEG-1:0]       seg_first_i,
    output logic [NSEG*SEG_W-1:0] sum_o,
    output logic [NSEG-1:0]       seg_cout_o
);

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        logic [SEG_W-1:0] a_seg;
        logic [SEG_W-1:0] b_inv;
        logic             cin;
        logic [SEG_W:0]   t;

        assign a_seg = a_i[i*SEG_W +: SEG_W];
        assign b_inv = b_i[i*SEG_W +: SEG_W] ^ {SEG_W{sub_i}};

        if (i == 0) begin : g_head
            assign cin = sub_i;
        end else begin : g_link
            // a lane edge restarts the chain with the subtract carry-in
            assign cin = seg_first_i[i] ? sub_i : g_seg[i-1].t[SEG_W];
        end

        assign t = {1'b0, a_seg} + {1'b0, b_inv} + {{SEG_W{1'b0}}, cin};
        assign sum_o[i*SEG_W +: SEG_W] = t[SEG_W-1:0];
        assign seg_cout_o[i] = t[SEG_W];
    end

endmodule

// File: rtl/lane_post.sv
module lane_post
    import plad_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [LW-1:0] sum_i,
    input  logic          ext_i,
    input  logic          is_signed_i,
    input  logic          is_sub_i,
    input  logic [1:0]    mode_i,
    output logic [LW-1:0] res_o,
    output logic          sat_o
);

    add_mode_e        md;
    logic [LW-1:0]    half;
    logic [LW-1:0]    rhalf;
    logic             ovf;
    logic [LW-1:0]    clamp;

    assign md = add_mode_e'(mode_i);

    always_comb begin
        // {ext, sum} is the exact lane value; shifting pulls ext in on top
        half  = {ext_i, sum_i[LW-1:1]};
        // floor((v+1)/2) equals floor(v/2) plus the dropped low bit
        rhalf = half + LW'(sum_i[0]);

        if (is_signed_i) begin
            ovf   = ext_i ^ sum_i[LW-1];
            clamp = ext_i ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
        end else begin
            ovf   = ext_i;
            clamp = is_sub_i ? {LW{1'b0}} : {LW{1'b1}};
        end

        sat_o = 1'b0;
        unique case (md)
            MD_WRAP:  res_o = sum_i;
            MD_SAT: begin
                res_o = ovf ? clamp : sum_i;
                sat_o = ovf;
            end
            MD_HALF:  res_o = half;
            MD_RHALF: res_o = rhalf;
            default:  res_o = sum_i;
        endcase
    end

endmodule

// File: rtl/packed_lane_adder.sv
module packed_lane_adder
    import plad_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SEG_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               lane_size,
    input  logic                     is_signed,
    input  logic                     is_sub,
    input  logic [1:0]               mode,
    input  logic [VEC_W-1:0]         op_a,
    input  logic [VEC_W-1:0]         op_b,
    input  logic                     sat_clr,
    output logic                     out_valid,
    output logic [VEC_W-1:0]         result,
    output logic [VEC_W/SEG_W-1:0]   lane_sat,
    output logic                     sat_status
);

    localparam int NSEG = VEC_W / SEG_W;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
        logic [NSEG-1:0]  sat;
        logic             sticky;
    } plad_state_t;

    plad_state_t st_d, st_q;

    logic [NSEG-1:0]  seg_first;
    logic [VEC_W-1:0] seg_sum;
    logic [NSEG-1:0]  seg_cout;
    logic [VEC_W-1:0] res_v [NUM_SIZES];
    logic [NSEG-1:0]  sat_v [NUM_SIZES];
    logic [NSEG-1:0]  sat_sel;

    always_comb begin
        for (int i = 0; i < NSEG; i++) begin
            seg_first[i] = ((i & ((1 << lane_size) - 1)) == 0);
        end
    end

    seg_adder #(
        .NSEG (NSEG),
        .SEG_W(SEG_W)
    ) u_adder (
        .a_i        (op_a),
        .b_i        (op_b),
        .sub_i      (is_sub),
        .seg_first_i(seg_first),
        .sum_o      (seg_sum),
        .seg_cout_o (seg_cout)
    );

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_sz
        localparam int LW  = SEG_W << k;
        localparam int NL  = NSEG >> k;
        localparam int SPL = 1 << k;

        logic [VEC_W-1:0] r;
        logic [NL-1:0]    s;

        for (genvar j = 0; j < NL; j++) begin : g_ln
            localparam int TOP = (j + 1) * SPL - 1;
            localparam int MSB = (TOP + 1) * SEG_W - 1;

            logic ext;
            // extra bit: extended operand tops plus carry out of the lane
            assign ext = (is_signed & op_a[MSB])
                       ^ ((is_signed & op_b[MSB]) ^ is_sub)
                       ^ seg_cout[TOP];

            lane_post #(.LW(LW)) u_post (
                .sum_i      (seg_sum[j*LW +: LW]),
                .ext_i      (ext),
                .is_signed_i(is_signed),
                .is_sub_i   (is_sub),
                .mode_i     (mode),
                .res_o      (r[j*LW +: LW]),
                .sat_o      (s[j])
            );
        end

        assign res_v[k] = r;
        assign sat_v[k] = NSEG'(s);
    end

    assign sat_sel = sat_v[lane_size];

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = res_v[lane_size];
            st_d.sat = sat_sel;
        end
        st_d.sticky = (sat_clr ? 1'b0 : st_q.sticky) | (in_valid & (|sat_sel));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign result     = st_q.res;
    assign lane_sat   = st_q.sat;
    assign sat_status = st_q.sticky;

    // R7
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(lane_sat)));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_status && !sat_clr) |=> sat_status);

    // R8
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr && !(in_valid && (|sat_sel))) |=> !sat_status);

    // R4
    nosat_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != MD_SAT) |=> (lane_sat == '0));

    // R4
    lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_size == SZ_64) |=> ((lane_sat >> (NSEG >> 3)) == '0));

endmodule

// File: tb/packed_lane_adder_tb.sv
module packed_lane_adder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   lane_size = 2'd0;
    logic         is_signed = 1'b0;
    logic         is_sub = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic         sat_clr = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic [15:0]  lane_sat;
    logic         sat_status;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    packed_lane_adder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .lane_size (lane_size),
        .is_signed (is_signed),
        .is_sub    (is_sub),
        .mode      (mode),
        .op_a      (op_a),
        .op_b      (op_b),
        .sat_clr   (sat_clr),
        .out_valid (out_valid),
        .result    (result),
        .lane_sat  (lane_sat),
        .sat_status(sat_status)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // per-lane reference computed with wide signed arithmetic
    task automatic model(input int sz, input int md, input bit sg, input bit sb,
                         input logic [127:0] a, input logic [127:0] b,
                         output logic [127:0] r, output logic [15:0] f);
        int W = 8 << sz;
        int n = 16 >> sz;
        logic [127:0] m128;
        m128 = (W == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << W) - 1);
        r = '0;
        f = '0;
        for (int l = 0; l < n; l++) begin
            logic [63:0] la, lb, lr;
            logic signed [67:0] ea, eb, v, lo, hi, rv;
            bit fl;
            la = 64'((a >> (l*W)) & m128);
            lb = 64'((b >> (l*W)) & m128);
            ea = $signed({4'b0, la});
            eb = $signed({4'b0, lb});
            if (sg && la[W-1]) ea = ea - (68'sd1 <<< W);
            if (sg && lb[W-1]) eb = eb - (68'sd1 <<< W);
            v  = sb ? (ea - eb) : (ea + eb);
            fl = 1'b0;
            case (md)
                0: rv = v;
                1: begin
                    lo = sg ? -(68'sd1 <<< (W-1)) : 68'sd0;
                    hi = sg ? ((68'sd1 <<< (W-1)) - 68'sd1) : ((68'sd1 <<< W) - 68'sd1);
                    rv = v;
                    if (v > hi) begin rv = hi; fl = 1'b1; end
                    if (v < lo) begin rv = lo; fl = 1'b1; end
                end
                2: rv = v >>> 1;
                default: rv = (v + 68'sd1) >>> 1;
            endcase
            lr = rv[63:0] & m128[63:0];
            r  = r | (128'(lr) << (l*W));
            f[l] = fl;
        end
    endtask

    function automatic logic [127:0] gen_vec(input int sz);
        int W = 8 << sz;
        int n = 16 >> sz;
        logic [127:0] v = '0;
        logic [63:0] m;
        m = (W == 64) ? {64{1'b1}} : ((64'd1 << W) - 1);
        for (int l = 0; l < n; l++) begin
            logic [63:0] x;
            case ($urandom % 5)
                0: x = '0;
                1: x = m;
                2: x = 64'd1 << (W-1);
                3: x = m >> 1;
                default: x = {$urandom, $urandom} & m;
            endcase
            v = v | (128'(x) << (l*W));
        end
        return v;
    endfunction

    function automatic string tag_of(input int md, input bit sg);
        case (md)
            0: return "R2";
            1: return sg ? "R3" : "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input int sz, input int md, input bit sg, input bit sb,
                         input logic [127:0] a, input logic [127:0] b);
        in_valid  = 1'b1;
        lane_size = 2'(sz);
        mode      = 2'(md);
        is_signed = sg;
        is_sub    = sb;
        op_a      = a;
        op_b      = b;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] er, a, b, prev;
        logic [15:0]  ef;

        repeat (3) @(negedge clk);
        // R9: outputs during reset
        chk("R9", "out_valid", 128'(out_valid), '0);
        chk("R9", "result", result, '0);
        chk("R9", "lane_sat", 128'(lane_sat), '0);
        chk("R9", "sat_status", 128'(sat_status), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: lane edges stop the carry; same operands, two lane sizes
        apply(0, 0, 0, 0, {8{16'h00FF}}, {8{16'h0001}});
        chk("R1", "8-bit lanes", result, '0);
        apply(1, 0, 0, 0, {8{16'h00FF}}, {8{16'h0001}});
        chk("R1", "16-bit lanes", result, {8{16'h0100}});
        apply(2, 0, 0, 1, {4{32'h0000_0000}}, {4{32'h0000_0001}});
        chk("R1", "32-bit borrow", result, {4{32'hFFFF_FFFF}});

        // R2..R6 sweep over every configuration
        for (int sz = 0; sz < 4; sz++) begin
            for (int md = 0; md < 4; md++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    for (int sb = 0; sb < 2; sb++) begin
                        for (int t = 0; t < 30; t++) begin
                            a = gen_vec(sz);
                            b = gen_vec(sz);
                            model(sz, md, sg[0], sb[0], a, b, er, ef);
                            apply(sz, md, sg[0], sb[0], a, b);
                            chk(tag_of(md, sg[0]), "result", result, er);
                            chk("R4", "lane_sat", 128'(lane_sat), 128'(ef));
                            if (t == 0) chk("R7", "out_valid high", 128'(out_valid), 128'd1);
                        end
                    end
                end
            end
        end

        // R7: idle cycle holds the outputs
        prev = result;
        in_valid = 1'b0;
        op_a = ~op_a;
        op_b = ~op_b;
        @(negedge clk);
        chk("R7", "out_valid low", 128'(out_valid), '0);
        chk("R7", "result held", result, prev);

        // R8: sticky status set, held, cleared, and clear loses to new clamp
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        chk("R8", "cleared", 128'(sat_status), '0);
        apply(0, 1, 0, 0, {16{8'hF0}}, {16{8'h20}});
        chk("R8", "set on clamp", 128'(sat_status), 128'd1);
        chk("R4", "unsigned add clamp", result, {16{8'hFF}});
        apply(0, 1, 0, 0, {16{8'h01}}, {16{8'h01}});
        chk("R8", "held", 128'(sat_status), 128'd1);
        chk("R4", "no clamp flags", 128'(lane_sat), '0);
        in_valid = 1'b0;
        sat_clr  = 1'b1;
        @(negedge clk);
        chk("R8", "clear", 128'(sat_status), '0);
        apply(3, 1, 1, 1, {2{64'h8000_0000_0000_0000}}, {2{64'd1}});
        sat_clr = 1'b0;
        chk("R8", "clamp beats clear", 128'(sat_status), 128'd1);
        chk("R3", "signed min clamp", result, {2{64'h8000_0000_0000_0000}});
        chk("R4", "64-bit flags", 128'(lane_sat), 128'h3);

        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule